// File: doc/BRIEF.md
# Time-Aligned Pulse Generator

This block drives a set of output pins from a free-running time-of-day nanosecond count. Each pin has its own control word and two period registers, and it runs in one of two modes. In free-running mode it is a programmable square-wave source. The pin alternates between a high phase and a low phase, and each phase lasts for the nanosecond value held in its register. In second-aligned mode the same two registers are read differently. The low register gives the offset of a single pulse from the start of each second, and the high register gives the width of that pulse.

The nanosecond input is sampled once per clock. Each clock cycle stands for `STEP_NS` nanoseconds of time. A second boundary is detected when a sample is smaller than the one before it, so the block needs no separate seconds input. Software or a sequencer programs the pins through a single-cycle write port that selects a pin and a register. A control write that sets the run bit starts or restarts the pin. A control write that clears the run bit stops the pin.

Top module: `tod_pulse_gen`

## Requirements
- R1: After a synchronous active-low reset every pin output is low and stays low until a run command is written.
- R2: A write with `wr_en` high acts on the pin given by `wr_pin`. `wr_sel` 0 selects the control word: bit 0 set means run and clear means stop, bit 1 selects second-aligned mode. `wr_sel` 1 writes the high register and `wr_sel` 2 writes the low register, each in ns. A write to one pin never changes the output of another pin.
- R3: A run command with bit 1 clear drives the pin high in the cycle after the write.
- R4: In free-running mode the pin stays high for ceil(H/STEP_NS) cycles and then low for ceil(L/STEP_NS) cycles, and this repeats. H and L are the effective high and low register values.
- R5: Any period value below 7 ns is used as 7 ns. This applies to both registers in free-running mode and to the pulse width in second-aligned mode. With STEP_NS = 4, a value of 0 or 3 therefore lasts 2 cycles.
- R6: A stop command drives the pin low in the next cycle and holds it low. A later run command starts again with a full high phase.
- R7: A run command with bit 1 set drives the pin low in the next cycle. Afterwards the pin rises in the cycle after the first nanosecond sample in the current second that is greater than or equal to the low register value.
- R8: A second-aligned pulse stays high for ceil(max(H,7)/STEP_NS) cycles and then returns low.
- R9: At most one pulse is produced per second. If the run command arrives after the offset has already passed in the current second, the first pulse waits for the next second.
- R10: With an offset of 0, the pulse rises in the cycle after the first sample of a new second, that is, the sample that is lower than the sample before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tod_ns | input | NS_W | Time-of-day nanoseconds within the current second |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_pin | input | PIN_W | Pin addressed by the write |
| wr_sel | input | 2 | Register select: 0 control, 1 high, 2 low |
| wr_data | input | NS_W | Write data: control bits or a period in ns |
| pulse_out | output | NUM_PINS | One output per pin |

## Verification
Free-running patterns are tried with a period of 20/12 ns, with sub-minimum values (3/0 ns) and with an asymmetric 36/8 ns pair. These tell apart correct phase-length rounding, clamping and per-pin isolation. A stop in the middle of a high phase, followed by a restart, shows whether the down-counter is reset. Second-aligned pins are armed after their offset has passed, so the first pulse must wait for the rollover. They are armed with offsets of 0, 100 and 102 ns, which separates rise on the wrap sample from rise on first equal-or-greater when the offset is not a step multiple. A backward jump of the time input then checks that a boundary re-arms every pin, and that a pin armed before its offset fires within the same second.

// File: rtl/tpo_pkg.sv
// Package: shared encodings for the time-aligned pulse generator.
// Assumes a write port carries one register access per cycle.
package tpo_pkg;

    // Register selected by a write
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_HIGH = 2'd1,
        SEL_LOW  = 2'd2,
        SEL_NONE = 2'd3
    } tpo_sel_e;

    // Control word bit positions
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_SYNC_BIT = 1;

    // Smallest period the engine will count, in ns
    localparam int MIN_PERIOD_NS = 7;

endpackage

// File: rtl/tpo_sec_edge.sv
// Module: tpo_sec_edge
// Flags the first sample of a new second, seen as a sample lower than the previous one.
// Assumes the nanosecond count only moves forward within a second.
module tpo_sec_edge #(
    parameter int NS_W = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NS_W-1:0] tod_i,
    output logic            wrap_o
);

    logic [NS_W-1:0] prev_q;

    // Remember the previous nanosecond sample
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= tod_i;
    end

    assign wrap_o = (tod_i < prev_q);

endmodule

// File: rtl/tpo_pin_regs.sv
// Module: tpo_pin_regs
// Holds the high and low period registers of one pin and decodes run and stop commands.
// Assumes the write data is as wide as a period register.
module tpo_pin_regs
    import tpo_pkg::*;
#(
    parameter int NS_W    = 30,
    parameter int PIN_W   = 2,
    parameter int PIN_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [PIN_W-1:0] wr_pin_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [NS_W-1:0]  wr_data_i,
    output logic [NS_W-1:0]  hi_o,
    output logic [NS_W-1:0]  lo_o,
    output logic             start_o,
    output logic             stop_o,
    output logic             sync_o
);

    logic      hit;
    tpo_sel_e  sel;

    assign hit = wr_en_i && (wr_pin_i == PIN_W'(PIN_IDX));
    assign sel = tpo_sel_e'(wr_sel_i);

    // Capture period registers on their selected writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_o <= '0;
            lo_o <= '0;
        end else if (hit) begin
            if (sel == SEL_HIGH) hi_o <= wr_data_i;
            if (sel == SEL_LOW)  lo_o <= wr_data_i;
        end
    end

    // Decode control writes into one-cycle commands
    always_comb begin
        start_o = hit && (sel == SEL_CTRL) &&  wr_data_i[CTRL_RUN_BIT];
        stop_o  = hit && (sel == SEL_CTRL) && !wr_data_i[CTRL_RUN_BIT];
        sync_o  = wr_data_i[CTRL_SYNC_BIT];
    end

    AST_HIGH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && sel == SEL_HIGH) |=> (hi_o == $past(wr_data_i))); // R2
    AST_LOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && sel == SEL_LOW) |=> (lo_o == $past(wr_data_i))); // R2

endmodule

// File: rtl/tpo_wave_engine.sv
// Module: tpo_wave_engine
// Generates one pin's waveform: a free-running high/low alternation, or one pulse
// per second at a phase offset. Time advances STEP_NS ns per clock cycle.
// Assumes start and stop never arrive in the same cycle.
module tpo_wave_engine
    import tpo_pkg::*;
#(
    parameter int NS_W    = 30,
    parameter int STEP_NS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NS_W-1:0] tod_i,
    input  logic            wrap_i,
    input  logic            start_i,
    input  logic            stop_i,
    input  logic            sync_i,
    input  logic [NS_W-1:0] hi_i,
    input  logic [NS_W-1:0] lo_i,
    output logic            out_o
);

    localparam logic [NS_W-1:0] STEP = NS_W'(STEP_NS);
    localparam logic [NS_W-1:0] MINP = NS_W'(MIN_PERIOD_NS);

    logic            run_q;
    logic            sync_q;
    logic            fired_q;
    logic            out_q;
    logic [NS_W-1:0] cnt_q;

    logic [NS_W-1:0] hi_eff;
    logic [NS_W-1:0] lo_eff;
    logic            fired_eff;
    logic            fire;
    logic            cnt_done;

    // Clamp periods and find the second-aligned trigger
    always_comb begin
        hi_eff    = (hi_i < MINP) ? MINP : hi_i;
        lo_eff    = (lo_i < MINP) ? MINP : lo_i;
        fired_eff = fired_q && !wrap_i;
        fire      = !fired_eff && (tod_i >= lo_i);
        cnt_done  = (cnt_q <= STEP);
    end

    // Pin state machine and nanosecond down-counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            sync_q  <= 1'b0;
            fired_q <= 1'b0;
            out_q   <= 1'b0;
            cnt_q   <= '0;
        end else if (stop_i) begin
            run_q   <= 1'b0;
            fired_q <= 1'b0;
            out_q   <= 1'b0;
            cnt_q   <= '0;
        end else if (start_i) begin
            run_q   <= 1'b1;
            sync_q  <= sync_i;
            out_q   <= !sync_i;
            cnt_q   <= sync_i ? '0 : hi_eff;
            fired_q <= sync_i && (tod_i >= lo_i);
        end else if (run_q && sync_q) begin
            if (fire) begin
                out_q   <= 1'b1;
                cnt_q   <= hi_eff;
                fired_q <= 1'b1;
            end else begin
                fired_q <= fired_eff;
                if (out_q) begin
                    if (cnt_done) begin
                        out_q <= 1'b0;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q - STEP;
                    end
                end
            end
        end else if (run_q) begin
            if (cnt_done) begin
                out_q <= !out_q;
                cnt_q <= out_q ? lo_eff : hi_eff;
            end else begin
                cnt_q <= cnt_q - STEP;
            end
        end
    end

    assign out_o = out_q;

    AST_FREE_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !sync_i) |=> out_o); // R3
    AST_SYNC_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && sync_i) |=> !out_o); // R7
    AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !out_o); // R6
    AST_FREE_EDGE_AT_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !sync_q && !$past(start_i) && (out_q != $past(out_q)))
            |-> ($past(cnt_q) <= STEP)); // R4
    AST_SYNC_RISE_PAST_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && sync_q && $rose(out_q)) |-> ($past(tod_i) >= $past(lo_i))); // R7
    AST_ONE_PULSE_PER_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && sync_q && $rose(out_q)) |-> (!$past(fired_q) || $past(wrap_i))); // R9

endmodule

// File: rtl/tod_pulse_gen.sv
// Module: tod_pulse_gen
// Top level: a shared second-boundary detector and one register bank plus
// waveform engine per output pin.
// Assumes NUM_PINS >= 2 and that tod_ns counts ns within the second.
module tod_pulse_gen
    import tpo_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int NS_W     = 30,
    parameter int STEP_NS  = 4,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NS_W-1:0]     tod_ns,
    input  logic                wr_en,
    input  logic [PIN_W-1:0]    wr_pin,
    input  logic [1:0]          wr_sel,
    input  logic [NS_W-1:0]     wr_data,
    output logic [NUM_PINS-1:0] pulse_out
);

    logic sec_wrap;

    tpo_sec_edge #(.NS_W(NS_W)) u_sec (
        .clk    (clk),
        .rst_n  (rst_n),
        .tod_i  (tod_ns),
        .wrap_o (sec_wrap)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [NS_W-1:0] hi;
        logic [NS_W-1:0] lo;
        logic            start;
        logic            stop;
        logic            sync;

        tpo_pin_regs #(.NS_W(NS_W), .PIN_W(PIN_W), .PIN_IDX(p)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (wr_en),
            .wr_pin_i  (wr_pin),
            .wr_sel_i  (wr_sel),
            .wr_data_i (wr_data),
            .hi_o      (hi),
            .lo_o      (lo),
            .start_o   (start),
            .stop_o    (stop),
            .sync_o    (sync)
        );

        tpo_wave_engine #(.NS_W(NS_W), .STEP_NS(STEP_NS)) u_eng (
            .clk     (clk),
            .rst_n   (rst_n),
            .tod_i   (tod_ns),
            .wrap_i  (sec_wrap),
            .start_i (start),
            .stop_i  (stop),
            .sync_i  (sync),
            .hi_i    (hi),
            .lo_i    (lo),
            .out_o   (pulse_out[p])
        );
    end

endmodule

// File: tb/sim_tod_pulse_gen.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected pin levels per cycle,
// a negedge monitor pops and compares them.
module sim_tod_pulse_gen;

    localparam int NP   = 4;
    localparam int STEP = 4;
    localparam int SEC  = 1000000000;

    typedef struct packed {
        int          cyc;
        int          pin;
        logic        val;
        logic [31:0] req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    int          tod = 0;
    int          prev_tod = 0;
    logic [29:0] tod_w;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_pin = '0;
    logic [1:0]  wr_sel = '0;
    logic [29:0] wr_data = '0;
    logic [3:0]  pulse_out;

    int   cyc = 0;
    int   n_tests = 0;
    int   n_fail = 0;
    exp_t q[$];

    // Second-aligned reference state, per pin
    bit          sm_on[NP];
    bit          sf[NP];
    int          sph[NP];
    int          sh[NP];
    int          busy[NP];
    logic [31:0] rtag[NP];
    logic [31:0] wtag[NP];

    assign tod_w = tod[29:0];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    tod_pulse_gen #(.NUM_PINS(NP), .NS_W(30), .STEP_NS(STEP)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tod_ns    (tod_w),
        .wr_en     (wr_en),
        .wr_pin    (wr_pin),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .pulse_out (pulse_out)
    );

    // Monitor: compare every expectation that falls due this cycle
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].cyc == cyc) begin
                n_tests++;
                if (pulse_out[q[i].pin] !== q[i].val) begin
                    n_fail++;
                    $display("FAIL %s pin %0d cycle %0d: actual %b expected %b",
                             q[i].req, q[i].pin, cyc, pulse_out[q[i].pin], q[i].val);
                end
                q.delete(i);
            end
        end
    end

    task automatic push(input int c, input int p, input logic v, input logic [31:0] t);
        exp_t e;
        e.cyc = c; e.pin = p; e.val = v; e.req = t;
        q.push_back(e);
    endtask

    task automatic purge(input int p, input int c);
        for (int i = q.size() - 1; i >= 0; i--)
            if (q[i].pin == p && q[i].cyc >= c) q.delete(i);
    endtask

    function automatic int phase_cycles(input int ns);
        int v;
        v = (ns < 7) ? 7 : ns;   // R5 clamp
        return (v + STEP - 1) / STEP;
    endfunction

    // One cycle: advance time (or jump), drive the write port, run the sync reference
    task automatic tick(input bit do_wr, input int p, input int s, input int d,
                        input bit do_jump, input int jv);
        @(negedge clk);
        prev_tod = tod;
        if (do_jump)                tod = jv;
        else if (tod + STEP >= SEC) tod = tod + STEP - SEC;
        else                        tod = tod + STEP;
        wr_en   = do_wr;
        wr_pin  = 2'(p);
        wr_sel  = 2'(s);
        wr_data = 30'(d);
        for (int k = 0; k < NP; k++) begin
            if (sm_on[k]) begin
                if (tod < prev_tod) sf[k] = 1'b0;
                if (!sf[k] && tod >= sph[k]) begin
                    sf[k] = 1'b1;
                    push(cyc + 1, k, 1'b1, rtag[k]);
                    for (int j = 2; j <= sh[k]; j++) push(cyc + j, k, 1'b1, wtag[k]);
                    push(cyc + sh[k] + 1, k, 1'b0, wtag[k]);
                    busy[k] = cyc + sh[k] + 1;
                end else if (cyc + 1 > busy[k]) begin
                    push(cyc + 1, k, 1'b0, "R9");
                end
            end
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 0, 0, 0, 1'b0, 0);
    endtask

    task automatic wr(input int p, input int s, input int d);
        tick(1'b1, p, s, d, 1'b0, 0);
    endtask

    // R3, R4: free-running start and its expected alternation
    task automatic start_free(input int p, input int hi, input int lo, input logic [31:0] t);
        int h;
        int l;
        wr(p, 1, hi);
        wr(p, 2, lo);
        wr(p, 0, 1);
        purge(p, cyc + 1);
        sm_on[p] = 1'b0;
        h = phase_cycles(hi);
        l = phase_cycles(lo);
        for (int n = 0; n < 3 * (h + l); n++)
            push(cyc + 1 + n, p, ((n % (h + l)) < h), (n == 0) ? 32'("R3") : t);
    endtask

    // R6: stop command
    task automatic stop_pin(input int p);
        wr(p, 0, 0);
        purge(p, cyc + 1);
        sm_on[p] = 1'b0;
        for (int n = 1; n <= 8; n++) push(cyc + n, p, 1'b0, "R6");
    endtask

    // R7: arm a second-aligned pin
    task automatic start_sync(input int p, input int hi, input int ph,
                              input logic [31:0] rt, input logic [31:0] wt);
        wr(p, 1, hi);
        wr(p, 2, ph);
        wr(p, 0, 3);
        purge(p, cyc + 1);
        push(cyc + 1, p, 1'b0, "R7");
        sm_on[p] = 1'b1;
        sf[p]    = (tod >= ph);
        sph[p]   = ph;
        sh[p]    = phase_cycles(hi);
        busy[p]  = cyc + 1;
        rtag[p]  = rt;
        wtag[p]  = wt;
    endtask

    initial begin
        for (int k = 0; k < NP; k++) begin
            sm_on[k] = 1'b0; sf[k] = 1'b0; sph[k] = 0; sh[k] = 0; busy[k] = 0;
            rtag[k] = "R7"; wtag[k] = "R8";
        end
        step(3);
        rst_n = 1'b1;
        // R1: all pins low after reset
        for (int k = 0; k < NP; k++)
            for (int j = 1; j <= 5; j++) push(cyc + j, k, 1'b0, "R1");
        step(6);

        // R4 free pattern, R5 clamp, R2 per-pin isolation with an idle neighbour
        start_free(0, 20, 12, "R4");
        for (int j = 1; j <= 40; j++) push(cyc + j, 3, 1'b0, "R2");
        start_free(1, 3, 0, "R5");
        start_free(2, 36, 8, "R2");
        step(40);

        // R6: stop in mid-phase, then restart with a full high phase
        stop_pin(0);
        step(3);
        start_free(0, 20, 12, "R6");
        step(30);
        stop_pin(0);
        stop_pin(1);
        stop_pin(2);
        step(10);

        // Second-aligned: armed after the offset, so pulses wait for the rollover (R9)
        tick(1'b0, 0, 0, 0, 1'b1, 999999000);
        start_sync(3, 40, 100, "R7", "R8");
        start_sync(2, 2, 0, "R10", "R5");
        start_sync(1, 16, 102, "R7", "R8");
        step(400);

        // Backward jump re-arms every pin; pin 0 armed before its offset (R7)
        tick(1'b0, 0, 0, 0, 1'b1, 5000);
        start_sync(0, 20, 6000, "R7", "R8");
        step(300);

        stop_pin(0);
        stop_pin(1);
        stop_pin(2);
        stop_pin(3);
        step(12);

        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R1 scoreboard: actual %0d pending expected 0", q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule